// File: doc/BRIEF.md
# Burst-of-Four Separate-Port SRAM Core

This block is a synthesizable model of a synchronous static memory with a write port and a read port that work independently. Every access moves exactly four data beats, one beat per cycle of the single fast clock that stands in for both edges of a double-rate interface. The storage array is four beats wide. Each address therefore names one wide word made of four beat-sized sub-words, and the address is two bits narrower than a count of beat locations would need.

On the write side, a gathering stage collects four beats together with the byte-lane enables that come with each beat. It then commits all four beats to the array in one masked operation, at the end of the last beat. On the read side, one wide word is fetched when a read is accepted, and the four sub-words are sent out on four consecutive cycles. A read that targets a write still being gathered sees that write's data merged lane by lane over the stored contents, including beats that reach the write port after the read was issued. Each port accepts a new command at most once every four cycles. A command that arrives too early is dropped and sets a sticky error flag.

Top module: `qburst_sram`

## Requirements
- R1: A read and a write can both be accepted in the same cycle, and each proceeds exactly as it would alone. A read of another address in that cycle returns that address's stored contents.
- R2: A write command is taken together with beat 0. Beats 1, 2 and 3 follow on the next three cycles. All four beats are committed in one array operation at the end of the beat-3 cycle, and beat k lands in sub-word k of the addressed word.
- R3: Each beat carries its own active-high lane enables. Enable bit i covers data bits [8i+7:8i] of that beat. A lane whose enable is low keeps its previous contents.
- R4: After an accepted read command, rd_valid is high for exactly the next four cycles. rd_data carries sub-word 0, then 1, 2 and 3 on those cycles. While rd_valid is low, rd_data is zero.
- R5: Every address holds four beats of its own. Writing one address leaves every other address unchanged.
- R6: A read accepted in the same cycle as a write command to that address, or while that write is still gathering, returns the write's data merged by lane over the old contents. This includes beats that arrive after the read command.
- R7: A read accepted before the write command to the same address returns the contents from before that write.
- R8: A command on a port is accepted only when that port has no burst still in progress past the current cycle. A command arriving earlier is ignored: an ignored write does not change its target address, and an ignored read adds no beats. A command exactly four cycles after the previous one is accepted, and back-to-back reads keep rd_valid high without a gap.
- R9: cmd_err goes high after any ignored command and stays high until reset.
- R10: While and after reset, rd_valid, rd_data and cmd_err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one beat per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Write command, sampled with beat 0 |
| wr_addr | input | ADDR_W | Wide-word address of the write |
| wr_data | input | DATA_W | Write beat data |
| wr_be | input | LANES | Per-beat lane enables, active high |
| rd_cmd | input | 1 | Read command |
| rd_addr | input | ADDR_W | Wide-word address of the read |
| rd_valid | output | 1 | High on each cycle that carries a read beat |
| rd_data | output | DATA_W | Read beat data, zero when idle |
| cmd_err | output | 1 | Sticky flag for a dropped command |

## Verification
Write bursts with all lanes enabled are set against bursts with a different enable pattern on every beat. This separates the per-beat lane masking from a mask taken once per command. A read to the same address is placed at each offset from zero to four cycles after its write command, and once one cycle before it. These placements separate the merge from the gather registers, the capture of a beat that arrives in the read cycle, the later snooped beats, a plain array read, and the old-data ordering. Commands are also sent inside a burst and exactly at the four-cycle boundary, and a read and a write to different addresses are started in the same cycle. This shows that dropping works, that the boundary is seamless, and that the two ports do not interfere.

// File: rtl/qb4_pkg.sv
// Package qb4_pkg
// Shared constants and types for the burst-of-four memory core.
// Assumes: every access is exactly four beats, so a beat index is two bits.
package qb4_pkg;
    localparam int BEATS   = 4;
    localparam int BEAT_IW = 2;
    typedef logic [BEAT_IW-1:0] beat_idx_t;
    localparam beat_idx_t LAST_BEAT = beat_idx_t'(BEATS - 1);
endpackage

// File: rtl/qb4_wr_gather.sv
// Module qb4_wr_gather
// Collects the four beats of a write burst and their per-beat lane enables,
// and raises a one-cycle commit in the beat-3 cycle with the assembled word.
// Assumes: the command comes with beat 0; a command during a burst is refused.
module qb4_wr_gather
    import qb4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LANES  = 1,
    parameter int ADDR_W = 10,
    localparam int WIDE_W = BEATS * DATA_W,
    localparam int MASK_W = BEATS * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic              acc,
    output logic              reject,
    output logic              active,
    output beat_idx_t         cur_idx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WIDE_W-1:0] hold_data,
    output logic [MASK_W-1:0] hold_be,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [WIDE_W-1:0] commit_data,
    output logic [MASK_W-1:0] commit_mask
);
    logic              busy_q;
    beat_idx_t         idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WIDE_W-1:0] data_q;
    logic [MASK_W-1:0] be_q;

    assign acc      = wr_cmd && !busy_q;
    assign reject   = wr_cmd && busy_q;
    assign active   = acc || busy_q;
    assign cur_idx  = busy_q ? idx_q : '0;
    assign cur_addr = busy_q ? addr_q : wr_addr;

    // Burst sequencing: beat counter and latched address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            addr_q <= '0;
        end else if (acc) begin
            busy_q <= 1'b1;
            idx_q  <= beat_idx_t'(1);
            addr_q <= wr_addr;
        end else if (busy_q) begin
            if (idx_q == LAST_BEAT) begin
                busy_q <= 1'b0;
            end
            idx_q <= idx_q + beat_idx_t'(1);
        end
    end

    // Beat storage: place each arriving beat and its enables in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            be_q   <= '0;
        end else if (active) begin
            data_q[int'(cur_idx)*DATA_W +: DATA_W] <= wr_data;
            be_q[int'(cur_idx)*LANES +: LANES]     <= wr_be;
        end
    end

    assign hold_data   = data_q;
    assign hold_be     = be_q;
    assign commit      = busy_q && (idx_q == LAST_BEAT);
    assign commit_addr = addr_q;

    // Commit word: stored beats 0..2 with the live beat 3 on top.
    always_comb begin
        commit_data = data_q;
        commit_mask = be_q;
        commit_data[(BEATS-1)*DATA_W +: DATA_W] = wr_data;
        commit_mask[(BEATS-1)*LANES +: LANES]   = wr_be;
    end
endmodule

// File: rtl/qb4_array.sv
// Module qb4_array
// Wide storage array with one lane-masked write port and one read port.
// Assumes: contents are not reset (a memory has no reset); reads are
// combinational and show the contents before a write on the same edge.
module qb4_array #(
    parameter int WIDE_W = 32,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 10,
    localparam int NLANE = WIDE_W / LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDE_W-1:0] wdata,
    input  logic [NLANE-1:0]  wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDE_W-1:0] rdata
);
    logic [WIDE_W-1:0] mem [DEPTH];

    // Masked write: only enabled lanes of the addressed word change.
    always_ff @(posedge clk) begin
        for (int l = 0; l < NLANE; l++) begin
            if (we && wmask[l]) begin
                mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qb4_rd_stage.sv
// Module qb4_rd_stage
// Captures one wide word per accepted read, merges in an open write burst to
// the same address, keeps snooping that burst's later beats, and sends the
// word out as four beats, sub-word 0 first.
// Assumes: the write gatherer's view (active, index, address, held beats)
// describes the burst that is in progress in the current cycle.
module qb4_rd_stage
    import qb4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LANES  = 1,
    parameter int ADDR_W = 10,
    localparam int LANE_W = DATA_W / LANES,
    localparam int WIDE_W = BEATS * DATA_W,
    localparam int MASK_W = BEATS * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WIDE_W-1:0] arr_rdata,
    input  logic              w_active,
    input  beat_idx_t         w_cur_idx,
    input  logic [ADDR_W-1:0] w_cur_addr,
    input  logic [WIDE_W-1:0] w_hold_data,
    input  logic [MASK_W-1:0] w_hold_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic              acc,
    output logic              reject,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic              valid_q;
    beat_idx_t         ridx_q;
    logic [WIDE_W-1:0] word_q;
    logic              snp_q;
    logic              hit;
    logic              hit_more;
    logic [WIDE_W-1:0] cap_word;
    logic [WIDE_W-1:0] snp_word;

    assign acc      = rd_cmd && (!valid_q || ridx_q == LAST_BEAT);
    assign reject   = rd_cmd && !acc;
    assign hit      = w_active && (w_cur_addr == rd_addr);
    assign hit_more = hit && (w_cur_idx != LAST_BEAT);

    // Capture merge: array word overlaid with held and live write beats.
    always_comb begin
        cap_word = arr_rdata;
        if (hit) begin
            for (int b = 0; b < BEATS; b++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (b < int'(w_cur_idx) && w_hold_be[b*LANES + l]) begin
                        cap_word[b*DATA_W + l*LANE_W +: LANE_W] =
                            w_hold_data[b*DATA_W + l*LANE_W +: LANE_W];
                    end else if (b == int'(w_cur_idx) && wr_be[l]) begin
                        cap_word[b*DATA_W + l*LANE_W +: LANE_W] =
                            wr_data[l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    // Snoop merge: overlay the live write beat on the captured word.
    always_comb begin
        snp_word = word_q;
        for (int b = 0; b < BEATS; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (b == int'(w_cur_idx) && wr_be[l]) begin
                    snp_word[b*DATA_W + l*LANE_W +: LANE_W] =
                        wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Output sequencing and word update (capture or snoop).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ridx_q  <= '0;
            word_q  <= '0;
            snp_q   <= 1'b0;
        end else if (acc) begin
            valid_q <= 1'b1;
            ridx_q  <= '0;
            word_q  <= cap_word;
            snp_q   <= hit_more;
        end else begin
            if (valid_q) begin
                if (ridx_q == LAST_BEAT) begin
                    valid_q <= 1'b0;
                end
                ridx_q <= ridx_q + beat_idx_t'(1);
            end
            if (snp_q && w_active) begin
                word_q <= snp_word;
                if (w_cur_idx == LAST_BEAT) begin
                    snp_q <= 1'b0;
                end
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_data  = valid_q ? word_q[int'(ridx_q)*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/qburst_sram.sv
// Module qburst_sram
// Top of the burst-of-four memory core: write gatherer, wide array, read
// stage, and a sticky flag for commands dropped because a burst was running.
// Assumes: DATA_W is a multiple of LANES; one beat per clock.
module qburst_sram
    import qb4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LANES  = 1,
    parameter int ADDR_W = 10,
    localparam int LANE_W = DATA_W / LANES,
    localparam int WIDE_W = BEATS * DATA_W,
    localparam int MASK_W = BEATS * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              rd_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_err
);
    logic              wr_acc;
    logic              wr_rej;
    logic              w_active;
    beat_idx_t         w_cur_idx;
    logic [ADDR_W-1:0] w_cur_addr;
    logic [WIDE_W-1:0] w_hold_data;
    logic [MASK_W-1:0] w_hold_be;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [WIDE_W-1:0] arr_wdata;
    logic [MASK_W-1:0] arr_wmask;
    logic [WIDE_W-1:0] arr_rdata;
    logic              rd_acc;
    logic              rd_rej;
    logic              err_q;

    qb4_wr_gather #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cmd      (wr_cmd),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .acc         (wr_acc),
        .reject      (wr_rej),
        .active      (w_active),
        .cur_idx     (w_cur_idx),
        .cur_addr    (w_cur_addr),
        .hold_data   (w_hold_data),
        .hold_be     (w_hold_be),
        .commit      (arr_we),
        .commit_addr (arr_waddr),
        .commit_data (arr_wdata),
        .commit_mask (arr_wmask)
    );

    qb4_array #(.WIDE_W(WIDE_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .wmask (arr_wmask),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    qb4_rd_stage #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_cmd      (rd_cmd),
        .rd_addr     (rd_addr),
        .arr_rdata   (arr_rdata),
        .w_active    (w_active),
        .w_cur_idx   (w_cur_idx),
        .w_cur_addr  (w_cur_addr),
        .w_hold_data (w_hold_data),
        .w_hold_be   (w_hold_be),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .acc         (rd_acc),
        .reject      (rd_rej),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    // Sticky error: set by any dropped command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wr_rej || rd_rej) begin
            err_q <= 1'b1;
        end
    end

    assign cmd_err = err_q;
endmodule

// File: rtl/qburst_sram_chk.sv
// Module qburst_sram_chk
// Protocol checker bound to qburst_sram: read framing, commit timing and
// the sticky error flag.
// Assumes: connected to the top's ports and its internal accept/commit nets.
module qburst_sram_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_cmd,
    input logic              rd_cmd,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              cmd_err,
    input logic              wr_acc,
    input logic              rd_acc,
    input logic              arr_we
);
    // R4: first beat follows an accepted read by one cycle.
    a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid);

    // R4: a read window lasts at least four cycles.
    a_r4_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> rd_valid ##1 rd_valid ##1 rd_valid ##1 rd_valid);

    // R4: idle output is zero.
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R2: commit happens in the beat-3 cycle of an accepted write.
    a_r2_commit_timing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> ##3 arr_we);

    // R2: no commit without a write accepted three cycles earlier.
    a_r2_no_stray_commit: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(wr_acc, 3));

    // R8: an accepted write is not followed by another accept next cycle.
    a_r8_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !wr_acc);

    // R9: a dropped command raises the flag.
    a_r9_flag_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_cmd && !wr_acc) || (rd_cmd && !rd_acc)) |=> cmd_err);

    // R9: the flag stays high until reset.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);
endmodule

bind qburst_sram qburst_sram_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (wr_cmd),
    .rd_cmd   (rd_cmd),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .cmd_err  (cmd_err),
    .wr_acc   (wr_acc),
    .rd_acc   (rd_acc),
    .arr_we   (arr_we)
);

// File: tb/test_qburst_sram.sv
// Directed bench for qburst_sram with 16-bit beats in two byte lanes.
module test_qburst_sram;
    localparam int DW = 16;
    localparam int LN = 2;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_cmd = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_be = '0;
    logic          rd_cmd = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          cmd_err;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] model [64];

    always #5 clk = ~clk;

    qburst_sram #(.DATA_W(DW), .LANES(LN), .ADDR_W(AW)) i_qburst_sram (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_cmd(rd_cmd), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] d, logic [7:0] m);
        logic [63:0] r = old;
        for (int k = 0; k < 8; k++) if (m[k]) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    // Drive one write burst; optionally raise a stray command on beat bad_at.
    task automatic wr_burst(int a, logic [63:0] d, logic [7:0] m,
                            int bad_at = -1, int bad_addr = 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_cmd  = (k == 0) || (k == bad_at);
            wr_addr = (k == bad_at) ? AW'(bad_addr) : AW'(a);
            wr_data = d[k*16 +: 16];
            wr_be   = m[k*2 +: 2];
        end
        @(negedge clk);
        wr_cmd = 1'b0; wr_be = '0; wr_data = '0;
        model[a] = merge(model[a], d, m);
    endtask

    // Issue one read and collect its four beats, checking rd_valid (R4).
    task automatic rd_burst(int a, output logic [63:0] q);
        @(negedge clk);
        rd_cmd = 1'b1; rd_addr = AW'(a);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) rd_cmd = 1'b0;
            check("R4 valid during beat", 64'(rd_valid), 64'd1);
            q[k*16 +: 16] = rd_data;
        end
    endtask

    task automatic t_reset;
        check("R10 rd_valid", 64'(rd_valid), 64'd0);
        check("R10 rd_data", 64'(rd_data), 64'd0);
        check("R10 cmd_err", 64'(cmd_err), 64'd0);
    endtask

    task automatic t_basic;
        logic [63:0] q;
        wr_burst(5, 64'h4444_3333_2222_1111, 8'hFF);
        rd_burst(5, q);
        check("R2 R4 beat order", q, 64'h4444_3333_2222_1111);
        @(negedge clk);
        check("R4 valid ends after four", 64'(rd_valid), 64'd0);
        check("R4 idle data zero", 64'(rd_data), 64'd0);
    endtask

    task automatic t_addr;
        logic [63:0] q;
        wr_burst(6, 64'hA0A1_B0B1_C0C1_D0D1, 8'hFF);
        rd_burst(5, q);
        check("R5 neighbour unchanged", q, model[5]);
        rd_burst(6, q);
        check("R5 own word", q, 64'hA0A1_B0B1_C0C1_D0D1);
    endtask

    task automatic t_mask;
        logic [63:0] q;
        wr_burst(5, 64'hEEEE_DDDD_CCCC_BBBB, 8'b11_00_10_01);
        rd_burst(5, q);
        check("R3 per-beat lanes", q, 64'hEEEE_3333_CC22_11BB);
    endtask

    task automatic t_concurrent;
        logic [63:0] q;
        logic [63:0] e5 = model[5];
        fork
            wr_burst(7, 64'h7777_6666_5555_4444, 8'hFF);
            rd_burst(5, q);
        join
        check("R1 read beside write", q, e5);
        rd_burst(7, q);
        check("R1 write beside read", q, 64'h7777_6666_5555_4444);
    endtask

    task automatic t_coherent(int off);
        logic [63:0] q;
        logic [63:0] e;
        logic [63:0] d = 64'h9A9B_8A8B_7A7B_6A6B + 64'(off);
        wr_burst(8, 64'h0102_0304_0506_0708, 8'hFF);
        e = merge(model[8], d, 8'b01_11_10_01);
        fork
            wr_burst(8, d, 8'b01_11_10_01);
            begin
                repeat (off) @(negedge clk);
                rd_burst(8, q);
            end
        join
        check($sformatf("R6 merge at offset %0d", off), q, e);
    endtask

    task automatic t_order;
        logic [63:0] q;
        logic [63:0] e;
        wr_burst(9, 64'h1212_3434_5656_7878, 8'hFF);
        e = model[9];
        fork
            rd_burst(9, q);
            begin
                @(negedge clk);
                wr_burst(9, 64'hFFFF_EEEE_DDDD_CCCC, 8'hFF);
            end
        join
        check("R7 old data before write", q, e);
        rd_burst(9, q);
        check("R7 new data afterwards", q, 64'hFFFF_EEEE_DDDD_CCCC);
    endtask

    task automatic t_back_to_back;
        logic [63:0] q1;
        logic [63:0] q2;
        fork
            rd_burst(5, q1);
            begin
                repeat (4) @(negedge clk);
                rd_burst(6, q2);
            end
        join
        check("R8 first of pair", q1, model[5]);
        check("R8 second of pair", q2, model[6]);
        @(negedge clk);
        check("R8 pair ends", 64'(rd_valid), 64'd0);
        check("R9 no error on spaced commands", 64'(cmd_err), 64'd0);
    endtask

    task automatic t_reject;
        logic [63:0] q;
        wr_burst(20, 64'h2020_2020_2020_2020, 8'hFF);
        wr_burst(22, 64'h2222_2222_2222_2222, 8'hFF);
        fork
            rd_burst(20, q);
            begin
                repeat (3) @(negedge clk);
                rd_cmd = 1'b1; rd_addr = AW'(22);
                @(negedge clk);
                rd_cmd = 1'b0;
            end
        join
        check("R8 read kept first data", q, model[20]);
        @(negedge clk);
        check("R8 dropped read adds no beats", 64'(rd_valid), 64'd0);
        check("R9 flag after dropped read", 64'(cmd_err), 64'd1);
        wr_burst(23, 64'h3131_3232_3333_3434, 8'hFF, 2, 22);
        rd_burst(22, q);
        check("R8 dropped write target unchanged", q, 64'h2222_2222_2222_2222);
        rd_burst(23, q);
        check("R8 running write intact", q, 64'h3131_3232_3333_3434);
        repeat (5) @(negedge clk);
        check("R9 flag stays high", 64'(cmd_err), 64'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 R10 flag cleared by reset", 64'(cmd_err), 64'd0);
        check("R10 valid low after reset", 64'(rd_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_addr();
        t_mask();
        t_concurrent();
        for (int off = 0; off <= 4; off++) t_coherent(off);
        t_order();
        t_back_to_back();
        t_reject();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule